// File: doc/BRIEF.md
# Clock Safe Mode Controller

This block holds the safe-mode state of a clock control unit for two domains: the normal domain (every clock other than debug) and the debug domain. While a domain is in safe mode, the block overrides the clock-control values that software has programmed and drives fixed safe values to the clock generation logic instead. The programmed values themselves are never altered. They sit on the block's inputs and reappear on the effective outputs as soon as software clears the safe-mode flag.

A cold reset puts both domains into safe mode. The reset controller can also raise a safe-mode request, which sets only the normal-domain flag. A warm reset places each domain into safe mode only when that domain's warm-response enable is set. Both enables come up set after a cold reset, and a warm reset does not change them. The only way to leave safe mode is a software clear strobe for the domain concerned.

All pins are plain control and status signals. No data streams through the block, so there is no valid/ready interface. The effective outputs are combinational from the flag registers and the programmed inputs, so they change in the same cycle that a flag changes.

Top module: `clk_safe_ctrl`

## Requirements
- R1: While `cold_rst` is high at a clock edge, both safe flags and both warm-response enables are 1 after that edge, whatever the other inputs are.
- R2: A `safe_req` pulse sets `safe_norm` at the next edge and leaves `safe_dbg`, `warm_en_norm` and `warm_en_dbg` unchanged.
- R3: A flag goes from 1 to 0 only at the edge after its clear strobe (`sw_clr_norm` or `sw_clr_dbg`). If a set source is active in the same cycle, the set wins and the flag stays 1.
- R4: A `warm_rst` pulse sets `safe_norm` only if `warm_en_norm` is 1 and sets `safe_dbg` only if `warm_en_dbg` is 1. A warm reset leaves both enables unchanged. The enables change only through `cfg_wr`, which loads `cfg_warm_norm` and `cfg_warm_dbg`.
- R5: The effective bypass bit of each PLL (1 = PLL bypassed to the main oscillator) is the OR of `safe_norm` and that PLL's programmed bypass bit. In safe mode all bits are therefore 1.
- R6: While `safe_norm` is 1, every normal divider field equals `NORM_DIV_RST`, and every flash source field (2 bits each, code 2'b01 = peripheral PLL) equals 2'b01.
- R7: While `safe_norm` is 1, every normal gate enable output is 1.
- R8: While `safe_dbg` is 1, every debug divider field equals `DBG_DIV_RST` and every debug gate enable is 1. Each domain's flag has no effect on the other domain's outputs.
- R9: While a domain's flag is 0, its effective outputs equal the programmed inputs. A change made to a programmed input during safe mode appears at the output in the same cycle that the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Cold reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset pulse |
| safe_req | input | 1 | Safe-mode request from the reset controller |
| sw_clr_norm | input | 1 | Software clear strobe for the normal flag |
| sw_clr_dbg | input | 1 | Software clear strobe for the debug flag |
| cfg_wr | input | 1 | Write strobe for the warm-response enables |
| cfg_warm_norm | input | 1 | Normal-domain warm-response enable value |
| cfg_warm_dbg | input | 1 | Debug-domain warm-response enable value |
| prg_pll_byp | input | NUM_PLL | Programmed PLL bypass bits |
| prg_ndiv | input | NUM_NDIV*DIV_W | Programmed normal divider codes |
| prg_ddiv | input | NUM_DDIV*DIV_W | Programmed debug divider codes |
| prg_fsel | input | NUM_FLASH*2 | Programmed flash clock source selects |
| prg_ngate | input | NUM_NGATE | Programmed normal gate enables |
| prg_dgate | input | NUM_DGATE | Programmed debug gate enables |
| eff_pll_byp | output | NUM_PLL | Effective PLL bypass and bypassed status |
| eff_ndiv | output | NUM_NDIV*DIV_W | Effective normal divider codes |
| eff_ddiv | output | NUM_DDIV*DIV_W | Effective debug divider codes |
| eff_fsel | output | NUM_FLASH*2 | Effective flash source selects |
| eff_ngate | output | NUM_NGATE | Effective normal gate enables |
| eff_dgate | output | NUM_DGATE | Effective debug gate enables |
| safe_norm | output | 1 | Normal-domain safe flag |
| safe_dbg | output | 1 | Debug-domain safe flag |
| warm_en_norm | output | 1 | Normal-domain warm-response enable |
| warm_en_dbg | output | 1 | Debug-domain warm-response enable |

## Verification
The assertions check the following on every cycle: the override values that are forced while a flag is set, the pass-through of programmed values while a flag is clear, the rule that a flag falls only after its clear strobe, and the stability of the enables across a warm reset. The bench scenarios cover the ordered cases. These include the warm-reset response under each combination of enables, a set and a clear arriving in the same cycle, and the debug and normal flags staying separate across a sequence of requests and clears. They also show that a programmed value changed during safe mode returns intact when the flag clears.

// File: rtl/clk_safe_pkg.sv
package clk_safe_pkg;
  localparam int FSEL_W = 2;

  typedef enum logic [FSEL_W-1:0] {
    FSRC_MAIN   = 2'b00,
    FSRC_PERIPH = 2'b01,
    FSRC_FABRIC = 2'b10
  } fsrc_e;

  typedef struct packed {
    logic norm;
    logic dbg;
  } dom_bits_t;
endpackage

// File: rtl/csm_flags.sv
module csm_flags (
  input  logic clk,
  input  logic cold_rst,
  input  logic warm_rst,
  input  logic safe_req,
  input  logic sw_clr_norm,
  input  logic sw_clr_dbg,
  input  logic cfg_wr,
  input  logic cfg_warm_norm,
  input  logic cfg_warm_dbg,
  output clk_safe_pkg::dom_bits_t safe_q,
  output clk_safe_pkg::dom_bits_t wen_q
);
  clk_safe_pkg::dom_bits_t set_d;
  clk_safe_pkg::dom_bits_t clr_d;

  always_comb begin
    set_d.norm = safe_req | (warm_rst & wen_q.norm);
    set_d.dbg  = warm_rst & wen_q.dbg;
    clr_d.norm = sw_clr_norm;
    clr_d.dbg  = sw_clr_dbg;
  end

  always_ff @(posedge clk) begin
    if (cold_rst) begin
      safe_q <= '{norm: 1'b1, dbg: 1'b1};
      wen_q  <= '{norm: 1'b1, dbg: 1'b1};
    end else begin
      // setting has priority over a software clear
      if (set_d.norm)      safe_q.norm <= 1'b1;
      else if (clr_d.norm) safe_q.norm <= 1'b0;
      if (set_d.dbg)       safe_q.dbg  <= 1'b1;
      else if (clr_d.dbg)  safe_q.dbg  <= 1'b0;
      if (cfg_wr) begin
        wen_q.norm <= cfg_warm_norm;
        wen_q.dbg  <= cfg_warm_dbg;
      end
    end
  end
endmodule

// File: rtl/csm_norm_mux.sv
module csm_norm_mux #(
  parameter int NUM_PLL      = 3,
  parameter int NUM_NDIV     = 4,
  parameter int NUM_FLASH    = 3,
  parameter int NUM_NGATE    = 8,
  parameter int DIV_W        = 4,
  parameter int NORM_DIV_RST = 1
) (
  input  logic                                       safe,
  input  logic [NUM_PLL-1:0]                         prg_pll_byp,
  input  logic [NUM_NDIV*DIV_W-1:0]                  prg_ndiv,
  input  logic [NUM_FLASH*clk_safe_pkg::FSEL_W-1:0]  prg_fsel,
  input  logic [NUM_NGATE-1:0]                       prg_ngate,
  output logic [NUM_PLL-1:0]                         eff_pll_byp,
  output logic [NUM_NDIV*DIV_W-1:0]                  eff_ndiv,
  output logic [NUM_FLASH*clk_safe_pkg::FSEL_W-1:0]  eff_fsel,
  output logic [NUM_NGATE-1:0]                       eff_ngate
);
  localparam int FW = clk_safe_pkg::FSEL_W;
  localparam logic [DIV_W-1:0] DIV_SAFE = DIV_W'(NORM_DIV_RST);

  assign eff_pll_byp = prg_pll_byp | {NUM_PLL{safe}};
  assign eff_ngate   = prg_ngate | {NUM_NGATE{safe}};

  for (genvar d = 0; d < NUM_NDIV; d++) begin : g_div
    assign eff_ndiv[d*DIV_W +: DIV_W] = safe ? DIV_SAFE : prg_ndiv[d*DIV_W +: DIV_W];
  end

  for (genvar f = 0; f < NUM_FLASH; f++) begin : g_fsel
    assign eff_fsel[f*FW +: FW] = safe ? clk_safe_pkg::FSRC_PERIPH : prg_fsel[f*FW +: FW];
  end
endmodule

// File: rtl/csm_dbg_mux.sv
module csm_dbg_mux #(
  parameter int NUM_DDIV    = 2,
  parameter int NUM_DGATE   = 4,
  parameter int DIV_W       = 4,
  parameter int DBG_DIV_RST = 2
) (
  input  logic                      safe,
  input  logic [NUM_DDIV*DIV_W-1:0] prg_ddiv,
  input  logic [NUM_DGATE-1:0]      prg_dgate,
  output logic [NUM_DDIV*DIV_W-1:0] eff_ddiv,
  output logic [NUM_DGATE-1:0]      eff_dgate
);
  localparam logic [DIV_W-1:0] DIV_SAFE = DIV_W'(DBG_DIV_RST);

  assign eff_dgate = prg_dgate | {NUM_DGATE{safe}};

  for (genvar d = 0; d < NUM_DDIV; d++) begin : g_div
    assign eff_ddiv[d*DIV_W +: DIV_W] = safe ? DIV_SAFE : prg_ddiv[d*DIV_W +: DIV_W];
  end
endmodule

// File: rtl/clk_safe_ctrl.sv
module clk_safe_ctrl #(
  parameter int NUM_PLL      = 3,
  parameter int NUM_NDIV     = 4,
  parameter int NUM_DDIV     = 2,
  parameter int NUM_FLASH    = 3,
  parameter int NUM_NGATE    = 8,
  parameter int NUM_DGATE    = 4,
  parameter int DIV_W        = 4,
  parameter int NORM_DIV_RST = 1,
  parameter int DBG_DIV_RST  = 2
) (
  input  logic                      clk,
  input  logic                      cold_rst,
  input  logic                      warm_rst,
  input  logic                      safe_req,
  input  logic                      sw_clr_norm,
  input  logic                      sw_clr_dbg,
  input  logic                      cfg_wr,
  input  logic                      cfg_warm_norm,
  input  logic                      cfg_warm_dbg,
  input  logic [NUM_PLL-1:0]        prg_pll_byp,
  input  logic [NUM_NDIV*DIV_W-1:0] prg_ndiv,
  input  logic [NUM_DDIV*DIV_W-1:0] prg_ddiv,
  input  logic [NUM_FLASH*2-1:0]    prg_fsel,
  input  logic [NUM_NGATE-1:0]      prg_ngate,
  input  logic [NUM_DGATE-1:0]      prg_dgate,
  output logic [NUM_PLL-1:0]        eff_pll_byp,
  output logic [NUM_NDIV*DIV_W-1:0] eff_ndiv,
  output logic [NUM_DDIV*DIV_W-1:0] eff_ddiv,
  output logic [NUM_FLASH*2-1:0]    eff_fsel,
  output logic [NUM_NGATE-1:0]      eff_ngate,
  output logic [NUM_DGATE-1:0]      eff_dgate,
  output logic                      safe_norm,
  output logic                      safe_dbg,
  output logic                      warm_en_norm,
  output logic                      warm_en_dbg
);
  clk_safe_pkg::dom_bits_t safe_q;
  clk_safe_pkg::dom_bits_t wen_q;

  csm_flags u_flags (
    .clk          (clk),
    .cold_rst     (cold_rst),
    .warm_rst     (warm_rst),
    .safe_req     (safe_req),
    .sw_clr_norm  (sw_clr_norm),
    .sw_clr_dbg   (sw_clr_dbg),
    .cfg_wr       (cfg_wr),
    .cfg_warm_norm(cfg_warm_norm),
    .cfg_warm_dbg (cfg_warm_dbg),
    .safe_q       (safe_q),
    .wen_q        (wen_q)
  );

  csm_norm_mux #(
    .NUM_PLL     (NUM_PLL),
    .NUM_NDIV    (NUM_NDIV),
    .NUM_FLASH   (NUM_FLASH),
    .NUM_NGATE   (NUM_NGATE),
    .DIV_W       (DIV_W),
    .NORM_DIV_RST(NORM_DIV_RST)
  ) u_norm (
    .safe       (safe_q.norm),
    .prg_pll_byp(prg_pll_byp),
    .prg_ndiv   (prg_ndiv),
    .prg_fsel   (prg_fsel),
    .prg_ngate  (prg_ngate),
    .eff_pll_byp(eff_pll_byp),
    .eff_ndiv   (eff_ndiv),
    .eff_fsel   (eff_fsel),
    .eff_ngate  (eff_ngate)
  );

  csm_dbg_mux #(
    .NUM_DDIV   (NUM_DDIV),
    .NUM_DGATE  (NUM_DGATE),
    .DIV_W      (DIV_W),
    .DBG_DIV_RST(DBG_DIV_RST)
  ) u_dbg (
    .safe     (safe_q.dbg),
    .prg_ddiv (prg_ddiv),
    .prg_dgate(prg_dgate),
    .eff_ddiv (eff_ddiv),
    .eff_dgate(eff_dgate)
  );

  assign safe_norm    = safe_q.norm;
  assign safe_dbg     = safe_q.dbg;
  assign warm_en_norm = wen_q.norm;
  assign warm_en_dbg  = wen_q.dbg;
endmodule

// File: rtl/clk_safe_ctrl_chk.sv
module clk_safe_ctrl_chk #(
  parameter int NUM_PLL      = 3,
  parameter int NUM_NDIV     = 4,
  parameter int NUM_DDIV     = 2,
  parameter int NUM_NGATE    = 8,
  parameter int NUM_DGATE    = 4,
  parameter int DIV_W        = 4,
  parameter int NORM_DIV_RST = 1,
  parameter int DBG_DIV_RST  = 2
) (
  input logic                      clk,
  input logic                      cold_rst,
  input logic                      warm_rst,
  input logic                      safe_req,
  input logic                      sw_clr_norm,
  input logic                      cfg_wr,
  input logic [NUM_NDIV*DIV_W-1:0] prg_ndiv,
  input logic [NUM_NGATE-1:0]      prg_ngate,
  input logic [NUM_PLL-1:0]        eff_pll_byp,
  input logic [NUM_NDIV*DIV_W-1:0] eff_ndiv,
  input logic [NUM_DDIV*DIV_W-1:0] eff_ddiv,
  input logic [NUM_NGATE-1:0]      eff_ngate,
  input logic [NUM_DGATE-1:0]      eff_dgate,
  input logic                      safe_norm,
  input logic                      safe_dbg,
  input logic                      warm_en_norm,
  input logic                      warm_en_dbg
);
  localparam logic [DIV_W-1:0] NRST = DIV_W'(NORM_DIV_RST);
  localparam logic [DIV_W-1:0] DRST = DIV_W'(DBG_DIV_RST);

  assert_cold_all_safe_R1: assert property (@(posedge clk)
    cold_rst |=> (safe_norm && safe_dbg && warm_en_norm && warm_en_dbg));

  assert_req_sets_norm_R2: assert property (@(posedge clk) disable iff (cold_rst)
    safe_req |=> safe_norm);

  assert_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (cold_rst)
    $fell(safe_norm) |-> $past(sw_clr_norm));

  assert_warm_keeps_en_R4: assert property (@(posedge clk) disable iff (cold_rst)
    (warm_rst && !cfg_wr) |=> ($stable(warm_en_norm) && $stable(warm_en_dbg)));

  assert_pll_bypassed_R5: assert property (@(posedge clk) disable iff (cold_rst)
    safe_norm |-> (eff_pll_byp == {NUM_PLL{1'b1}}));

  assert_norm_div_R6: assert property (@(posedge clk) disable iff (cold_rst)
    safe_norm |-> (eff_ndiv == {NUM_NDIV{NRST}}));

  assert_norm_gates_R7: assert property (@(posedge clk) disable iff (cold_rst)
    safe_norm |-> (eff_ngate == {NUM_NGATE{1'b1}}));

  assert_dbg_force_R8: assert property (@(posedge clk) disable iff (cold_rst)
    safe_dbg |-> ((eff_ddiv == {NUM_DDIV{DRST}}) && (eff_dgate == {NUM_DGATE{1'b1}})));

  assert_passthru_R9: assert property (@(posedge clk) disable iff (cold_rst)
    !safe_norm |-> ((eff_ngate == prg_ngate) && (eff_ndiv == prg_ndiv)));
endmodule

bind clk_safe_ctrl clk_safe_ctrl_chk #(
  .NUM_PLL     (NUM_PLL),
  .NUM_NDIV    (NUM_NDIV),
  .NUM_DDIV    (NUM_DDIV),
  .NUM_NGATE   (NUM_NGATE),
  .NUM_DGATE   (NUM_DGATE),
  .DIV_W       (DIV_W),
  .NORM_DIV_RST(NORM_DIV_RST),
  .DBG_DIV_RST (DBG_DIV_RST)
) i_chk (
  .clk         (clk),
  .cold_rst    (cold_rst),
  .warm_rst    (warm_rst),
  .safe_req    (safe_req),
  .sw_clr_norm (sw_clr_norm),
  .cfg_wr      (cfg_wr),
  .prg_ndiv    (prg_ndiv),
  .prg_ngate   (prg_ngate),
  .eff_pll_byp (eff_pll_byp),
  .eff_ndiv    (eff_ndiv),
  .eff_ddiv    (eff_ddiv),
  .eff_ngate   (eff_ngate),
  .eff_dgate   (eff_dgate),
  .safe_norm   (safe_norm),
  .safe_dbg    (safe_dbg),
  .warm_en_norm(warm_en_norm),
  .warm_en_dbg (warm_en_dbg)
);

// File: tb/test_clk_safe_ctrl.sv
module test_clk_safe_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic cold_rst = 1'b1, warm_rst = 1'b0, safe_req = 1'b0;
  logic sw_clr_norm = 1'b0, sw_clr_dbg = 1'b0;
  logic cfg_wr = 1'b0, cfg_warm_norm = 1'b0, cfg_warm_dbg = 1'b0;
  logic [2:0]  prg_pll_byp = 3'b010;
  logic [15:0] prg_ndiv    = 16'h7359;
  logic [7:0]  prg_ddiv    = 8'h5C;
  logic [5:0]  prg_fsel    = 6'b10_00_10;
  logic [7:0]  prg_ngate   = 8'hA5;
  logic [3:0]  prg_dgate   = 4'h9;
  logic [2:0]  eff_pll_byp;
  logic [15:0] eff_ndiv;
  logic [7:0]  eff_ddiv;
  logic [5:0]  eff_fsel;
  logic [7:0]  eff_ngate;
  logic [3:0]  eff_dgate;
  logic safe_norm, safe_dbg, warm_en_norm, warm_en_dbg;

  int checks = 0;
  int failures = 0;

  clk_safe_ctrl i_clk_safe_ctrl (
    .clk(clk), .cold_rst(cold_rst), .warm_rst(warm_rst), .safe_req(safe_req),
    .sw_clr_norm(sw_clr_norm), .sw_clr_dbg(sw_clr_dbg), .cfg_wr(cfg_wr),
    .cfg_warm_norm(cfg_warm_norm), .cfg_warm_dbg(cfg_warm_dbg),
    .prg_pll_byp(prg_pll_byp), .prg_ndiv(prg_ndiv), .prg_ddiv(prg_ddiv),
    .prg_fsel(prg_fsel), .prg_ngate(prg_ngate), .prg_dgate(prg_dgate),
    .eff_pll_byp(eff_pll_byp), .eff_ndiv(eff_ndiv), .eff_ddiv(eff_ddiv),
    .eff_fsel(eff_fsel), .eff_ngate(eff_ngate), .eff_dgate(eff_dgate),
    .safe_norm(safe_norm), .safe_dbg(safe_dbg),
    .warm_en_norm(warm_en_norm), .warm_en_dbg(warm_en_dbg)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge, ending at the falling edge after it
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk_norm_safe(input string req);
    check({req, " pll"}, 64'(eff_pll_byp), 64'h7);
    check({req, " ndiv"}, 64'(eff_ndiv), 64'h1111);
    check({req, " fsel"}, 64'(eff_fsel), 64'h15);
    check({req, " ngate"}, 64'(eff_ngate), 64'hFF);
  endtask

  task automatic chk_norm_prog(input string req);
    check({req, " pll"}, 64'(eff_pll_byp), 64'(prg_pll_byp));
    check({req, " ndiv"}, 64'(eff_ndiv), 64'(prg_ndiv));
    check({req, " fsel"}, 64'(eff_fsel), 64'(prg_fsel));
    check({req, " ngate"}, 64'(eff_ngate), 64'(prg_ngate));
  endtask

  task automatic chk_dbg(input string req, input logic safe);
    check({req, " ddiv"}, 64'(eff_ddiv), safe ? 64'h22 : 64'(prg_ddiv));
    check({req, " dgate"}, 64'(eff_dgate), safe ? 64'hF : 64'(prg_dgate));
  endtask

  task automatic clr_both();
    sw_clr_norm = 1'b1; sw_clr_dbg = 1'b1; cyc();
    sw_clr_norm = 1'b0; sw_clr_dbg = 1'b0;
  endtask

  task automatic t_cold();
    cold_rst = 1'b1; cyc(); cyc();
    cold_rst = 1'b0; cyc();
    check("R1 safe_norm", 64'(safe_norm), 64'h1);
    check("R1 safe_dbg", 64'(safe_dbg), 64'h1);
    check("R1 warm enables", 64'({warm_en_norm, warm_en_dbg}), 64'h3);
    chk_norm_safe("R5 R6 R7 cold");
    chk_dbg("R8 cold", 1'b1);
  endtask

  task automatic t_clear();
    sw_clr_norm = 1'b1; cyc(); sw_clr_norm = 1'b0;
    check("R3 norm cleared", 64'(safe_norm), 64'h0);
    check("R3 dbg kept", 64'(safe_dbg), 64'h1);
    chk_norm_prog("R9 norm after clear");
    chk_dbg("R8 dbg unaffected by norm", 1'b1);
    sw_clr_dbg = 1'b1; cyc(); sw_clr_dbg = 1'b0;
    check("R3 dbg cleared", 64'(safe_dbg), 64'h0);
    chk_dbg("R9 dbg after clear", 1'b0);
    repeat (3) cyc();
    check("R3 flags stay clear", 64'({safe_norm, safe_dbg}), 64'h0);
    check("R5 status follows own bit", 64'(eff_pll_byp), 64'h2);
  endtask

  task automatic t_safe_req();
    safe_req = 1'b1; cyc(); safe_req = 1'b0;
    check("R2 norm set", 64'(safe_norm), 64'h1);
    check("R2 dbg untouched", 64'(safe_dbg), 64'h0);
    check("R2 enables untouched", 64'({warm_en_norm, warm_en_dbg}), 64'h3);
    chk_norm_safe("R2 R5 R6 R7 req");
    chk_dbg("R8 dbg not forced by norm", 1'b0);
    clr_both();
  endtask

  task automatic t_warm_default();
    warm_rst = 1'b1; cyc(); warm_rst = 1'b0;
    check("R4 default both safe", 64'({safe_norm, safe_dbg}), 64'h3);
    check("R4 enables kept", 64'({warm_en_norm, warm_en_dbg}), 64'h3);
    clr_both();
  endtask

  task automatic t_warm_select();
    cfg_wr = 1'b1; cfg_warm_norm = 1'b0; cfg_warm_dbg = 1'b1; cyc(); cfg_wr = 1'b0;
    check("R4 enables written", 64'({warm_en_norm, warm_en_dbg}), 64'h1);
    warm_rst = 1'b1; cyc(); warm_rst = 1'b0;
    check("R4 only dbg safe", 64'({safe_norm, safe_dbg}), 64'h1);
    check("R4 enables kept by warm", 64'({warm_en_norm, warm_en_dbg}), 64'h1);
    chk_norm_prog("R8 norm unaffected by dbg");
    chk_dbg("R8 dbg forced", 1'b1);
    clr_both();
    cfg_wr = 1'b1; cfg_warm_norm = 1'b1; cfg_warm_dbg = 1'b0; cyc(); cfg_wr = 1'b0;
    warm_rst = 1'b1; cyc(); warm_rst = 1'b0;
    check("R4 only norm safe", 64'({safe_norm, safe_dbg}), 64'h2);
    clr_both();
    cfg_wr = 1'b1; cfg_warm_norm = 1'b0; cfg_warm_dbg = 1'b0; cyc(); cfg_wr = 1'b0;
    warm_rst = 1'b1; cyc(); warm_rst = 1'b0;
    check("R4 neither safe", 64'({safe_norm, safe_dbg}), 64'h0);
  endtask

  task automatic t_set_wins();
    safe_req = 1'b1; sw_clr_norm = 1'b1; cyc();
    safe_req = 1'b0; sw_clr_norm = 1'b0;
    check("R3 set beats clear", 64'(safe_norm), 64'h1);
  endtask

  task automatic t_preserve();
    prg_ngate = 8'h3C; prg_ndiv = 16'hBEEF; prg_pll_byp = 3'b000; cyc();
    chk_norm_safe("R9 forced while safe");
    sw_clr_norm = 1'b1; cyc(); sw_clr_norm = 1'b0;
    chk_norm_prog("R9 new program after clear");
    check("R9 ngate value", 64'(eff_ngate), 64'h3C);
  endtask

  task automatic t_cold_again();
    cold_rst = 1'b1; cyc(); cold_rst = 1'b0; cyc();
    check("R1 enables restored", 64'({warm_en_norm, warm_en_dbg}), 64'h3);
    check("R1 flags set", 64'({safe_norm, safe_dbg}), 64'h3);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_cold();
    t_clear();
    t_safe_req();
    t_warm_default();
    t_warm_select();
    t_set_wins();
    t_preserve();
    t_cold_again();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule